// File: doc/BRIEF.md
# External Static RAM Access Controller

This block exposes a small 32-word by 8-bit memory to on-chip logic and keeps the words in an external asynchronous static RAM. The RAM has an 18-bit address bus and a 16-bit bidirectional data bus. Its active-low chip-enable, output-enable, upper-byte and lower-byte controls are tied asserted. Only the active-low write strobe tells a read from a write.

A request is offered on `req_i` together with `we_i`, `addr_i` and `wdata_i`, and it is taken on a rising clock edge when `busy_o` is low. The controller registers the address and data. It drives the zero-extended address on the external bus and then steps a sequencer. The sequencer opens the write strobe only after an address setup interval and owns the data bus only while the strobe is low. For a read, it waits a programmable number of cycles before it samples the low byte of the bus. Every interval is a parameter counted in clock cycles, so the same logic can meet the RAM's nanosecond limits at different clock rates.

Top module: `sram_bridge`

## Requirements
- R1: While and after reset, `busy_o` is low, `sram_we_no` is high, `rdata_o` is 0 and `sram_addr_o` is 0, and the controller does not drive the data bus.
- R2: `sram_ce_no`, `sram_oe_no`, `sram_ub_no` and `sram_lb_no` are low at all times.
- R3: A request is taken only on an edge where `busy_o` is low. A request held high while `busy_o` is high is ignored: the stored word and the external address do not change.
- R4: `sram_addr_o` carries the taken 5-bit address in bits 4:0 and zeros in bits 17:5. It holds that value until the next request is taken.
- R5: For a write taken at edge E, `sram_we_no` stays high for SETUP_CYC cycles after E, goes low for WE_CYC cycles, then stays high for HOLD_CYC cycles. `busy_o` is high for exactly SETUP_CYC+WE_CYC+HOLD_CYC cycles after E.
- R6: The controller drives the data bus only while `sram_we_no` is low. It drives the write byte on bits 7:0 and zeros on bits 15:8. At all other times the bus is released, so a RAM that drives it whenever the strobe is high never conflicts with the controller.
- R7: For a read taken at edge E, `busy_o` is high for READ_CYC cycles. At the edge where it falls, `rdata_o` takes bits 7:0 of the data bus, and bits 15:8 have no effect.
- R8: `rdata_o` changes only at the end of a read. A write leaves it unchanged.
- R9: Each of the 32 locations can be written and read back. With the bench's cycle counts at 125 MHz, the external timing is met: strobe low at least 8 ns, address stable at least 8 ns and data stable at least 6 ns before the strobe rises, and data sampled at least 10 ns after the address changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Access sequence in progress |
| rdata_o | output | 8 | Last read byte |
| sram_addr_o | output | 18 | External address |
| sram_dq_io | inout | 16 | External data bus |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_ub_no | output | 1 | Upper byte select, active low |
| sram_lb_no | output | 1 | Lower byte select, active low |
| sram_we_no | output | 1 | Write strobe, active low |

## Verification
The bench runs with one setup cycle, one strobe cycle, one hold cycle and two read-wait cycles. Taking the request edge as E, the write strobe is due low in the first mid-cycle after E+1 and high again after E+2, and `busy_o` is due low after E+3. Read data is due in the mid-cycle after E+2, in the same sample where `busy_o` is first seen low. The bench steps through these points one falling clock edge at a time and samples at each of them. A behavioural RAM model adds nanosecond checks on the strobe width and on the address and data setup. It also checks, in every cycle, that the bus carries the RAM's own value whenever the RAM drives it.

// File: rtl/sram_bridge_pkg.sv
`timescale 1ns/1ps
package sram_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RWAIT
  } seq_state_e;
endpackage

// File: rtl/sram_bridge_req.sv
`timescale 1ns/1ps
module sram_bridge_req #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
    end else if (accept_i) begin
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_bridge_seq.sv
`timescale 1ns/1ps
module sram_bridge_seq
  import sram_bridge_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 1,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  output logic accept_o,
  output logic busy_o,
  output logic we_n_o,
  output logic drive_o,
  output logic cap_o
);
  localparam int MAX_W = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int MAX_R = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int MAX_C = (MAX_W > MAX_R) ? MAX_W : MAX_R;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;
  logic             we_n_q, drive_q;

  assign last     = (cnt_q == '0);
  assign accept_o = (state_q == ST_IDLE) && req_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign cap_o    = (state_q == ST_RWAIT) && last;
  assign we_n_o   = we_n_q;
  assign drive_o  = drive_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = last ? '0 : cnt_q - CNT_W'(1);
    case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = we_i ? ST_WSETUP : ST_RWAIT;
        cnt_d   = we_i ? CNT_W'(SETUP_CYC - 1) : CNT_W'(READ_CYC - 1);
      end
      ST_WSETUP: if (last) begin
        state_d = ST_WPULSE;
        cnt_d   = CNT_W'(WE_CYC - 1);
      end
      ST_WPULSE: if (last) begin
        state_d = ST_WHOLD;
        cnt_d   = CNT_W'(HOLD_CYC - 1);
      end
      ST_WHOLD:  if (last) state_d = ST_IDLE;
      ST_RWAIT:  if (last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      we_n_q  <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      // strobe and bus ownership come from flops so they switch on the same edge
      we_n_q  <= (state_d != ST_WPULSE);
      drive_q <= (state_d == ST_WPULSE);
    end
  end

  p_accept_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o);
  p_release_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> !drive_q);
  p_cap_ends_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !busy_o);
endmodule

// File: rtl/sram_bridge_rdcap.sv
`timescale 1ns/1ps
module sram_bridge_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= bus_i;
  end
endmodule

// File: rtl/sram_bridge.sv
`timescale 1ns/1ps
module sram_bridge #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int EXT_AW    = 18,
  parameter int EXT_DW    = 16,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 1,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [EXT_AW-1:0] sram_addr_o,
  inout  wire  [EXT_DW-1:0] sram_dq_io,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_ub_no,
  output logic              sram_lb_no,
  output logic              sram_we_no
);
  localparam int PAD_AW = EXT_AW - ADDR_W;
  localparam int PAD_DW = EXT_DW - DATA_W;

  logic              accept, drive, cap;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              unused_hi;

  sram_bridge_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i, .rst_ni,
    .accept_i (accept),
    .addr_i, .wdata_i,
    .addr_q_o (addr_q),
    .wdata_q_o(wdata_q)
  );

  sram_bridge_seq #(
    .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC),
    .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i,
    .accept_o(accept),
    .busy_o,
    .we_n_o  (sram_we_no),
    .drive_o (drive),
    .cap_o   (cap)
  );

  sram_bridge_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk_i, .rst_ni,
    .cap_i  (cap),
    .bus_i  (sram_dq_io[DATA_W-1:0]),
    .rdata_o
  );

  assign sram_addr_o = {{PAD_AW{1'b0}}, addr_q};
  assign sram_dq_io  = drive ? {{PAD_DW{1'b0}}, wdata_q} : {EXT_DW{1'bz}};
  assign unused_hi   = ^sram_dq_io[EXT_DW-1:DATA_W];

  assign sram_ce_no = 1'b0;
  assign sram_oe_no = 1'b0;
  assign sram_ub_no = 1'b0;
  assign sram_lb_no = 1'b0;

  p_addr_hold_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(sram_addr_o));
  p_addr_stable_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> $stable(sram_addr_o));
  p_rdata_kept_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |=> $stable(rdata_o));
endmodule

// File: tb/sram_bridge_tb.sv
`timescale 1ns/1ps
module sram_bridge_tb;
  localparam int TB_SETUP = 1;
  localparam int TB_PULSE = 1;
  localparam int TB_HOLD  = 1;
  localparam int TB_READ  = 2;
  localparam int TB_WTOT  = TB_SETUP + TB_PULSE + TB_HOLD;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        busy_o;
  logic [7:0]  rdata_o;
  logic [17:0] sram_addr_o;
  wire  [15:0] sram_dq;
  logic        sram_ce_no, sram_oe_no, sram_ub_no, sram_lb_no, sram_we_no;

  int vec = 0;
  int bad = 0;
  logic [7:0] shadow [32];

  always #4 clk_i = ~clk_i;

  sram_bridge #(.READ_CYC(TB_READ)) u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .busy_o, .rdata_o, .sram_addr_o,
    .sram_dq_io(sram_dq),
    .sram_ce_no, .sram_oe_no, .sram_ub_no, .sram_lb_no, .sram_we_no
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- external RAM model ----------------
  logic [15:0] mem [32];
  logic [15:0] ram_q;
  logic        we_late = 1'b1;
  logic [15:0] dq_late;
  realtime     t_dq_late = 0.0, t_addr = 0.0, t_fall = 0.0;
  bit          low_seen = 1'b0;
  wire         ram_on = sram_we_no && we_late && !sram_ce_no && !sram_oe_no;

  assign sram_dq = ram_on ? ram_q : 16'hzzzz;

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i]    = {8'(8'hC0 + i), 8'(i * 29 + 3)};
      shadow[i] = 8'(i * 29 + 3);
    end
    ram_q = mem[0];
  end

  always @(sram_we_no) we_late <= #2 sram_we_no;
  always @(sram_dq) begin
    dq_late   <= #1 sram_dq;
    t_dq_late <= #1 $realtime;
  end
  always @(sram_addr_o) begin
    t_addr = $realtime;
    ram_q <= #3 16'hxxxx;
    ram_q <= #10 mem[sram_addr_o[4:0]];
  end
  always @(negedge sram_we_no) if (rst_ni) begin
    t_fall   = $realtime;
    low_seen = 1'b1;
  end
  always @(posedge sram_we_no) if (rst_ni && low_seen) begin
    low_seen = 1'b0;
    chk($realtime - t_fall >= 8.0, "R9 strobe width", 32'($realtime - t_fall), 8);
    chk($realtime - t_addr >= 8.0, "R9 address setup", 32'($realtime - t_addr), 8);
    chk($realtime - t_dq_late >= 6.0, "R9 data setup", 32'($realtime - t_dq_late), 6);
    chk(dq_late[15:8] == 8'h00, "R6 upper lines zero", dq_late[15:8], 0);
    mem[sram_addr_o[4:0]] = dq_late;
    ram_q <= #10 dq_late;
  end

  // every mid-cycle: fixed controls, address extension, no bus conflict
  always @(negedge clk_i) if (rst_ni) begin
    chk({sram_ce_no, sram_oe_no, sram_ub_no, sram_lb_no} == 4'b0000, "R2 controls low",
        {sram_ce_no, sram_oe_no, sram_ub_no, sram_lb_no}, 0);
    chk(sram_addr_o[17:5] == '0, "R4 upper address zero", sram_addr_o, sram_addr_o[4:0]);
    if (ram_on) chk(sram_dq === ram_q, "R6 bus released", sram_dq, ram_q);
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit w, input logic [4:0] a, input logic [7:0] d);
    while (busy_o) @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o, "R3 taken when idle", busy_o, 1);
    chk(sram_addr_o == {13'd0, a}, "R4 address driven", sram_addr_o, a);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] rd_before;
    rd_before = rdata_o;
    issue(1'b1, a, d);
    for (int k = 0; k < TB_WTOT; k++) begin
      if (k > 0) @(negedge clk_i);
      if (k >= TB_SETUP && k < TB_SETUP + TB_PULSE) begin
        chk(!sram_we_no, "R5 strobe low", sram_we_no, 0);
        chk(sram_dq === {8'h00, d}, "R6 write data on bus", sram_dq, {8'h00, d});
      end else begin
        chk(sram_we_no, "R5 strobe high", sram_we_no, 1);
      end
      chk(busy_o, "R5 busy during write", busy_o, 1);
      chk(sram_addr_o == {13'd0, a}, "R4 address held", sram_addr_o, a);
    end
    @(negedge clk_i);
    chk(!busy_o, "R5 busy ends", busy_o, 0);
    chk(rdata_o == rd_before, "R8 rdata kept on write", rdata_o, rd_before);
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [4:0] a);
    issue(1'b0, a, 8'h00);
    for (int k = 1; k < TB_READ; k++) begin
      @(negedge clk_i);
      chk(busy_o, "R7 busy during read", busy_o, 1);
      chk(sram_we_no, "R7 strobe idle on read", sram_we_no, 1);
    end
    @(negedge clk_i);
    chk(!busy_o, "R7 busy ends", busy_o, 0);
    chk(rdata_o == shadow[a], "R7 read data", rdata_o, shadow[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    vec++; bad++;
    $display("FAIL R5 watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R1 reset busy", busy_o, 0);
    chk(sram_we_no, "R1 reset strobe", sram_we_no, 1);
    chk(rdata_o == 8'h00, "R1 reset rdata", rdata_o, 0);
    chk(sram_addr_o == '0, "R1 reset address", sram_addr_o, 0);
    chk(ram_on && sram_dq === ram_q, "R1 bus released in reset", sram_dq, ram_q);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o, "R1 idle after reset", busy_o, 0);

    // preloaded words carry nonzero upper bytes that must not reach rdata
    do_read(5'd3);
    do_read(5'd30);

    // boundaries
    do_write(5'd0, 8'h00);
    do_write(5'd31, 8'hFF);
    do_read(5'd31);
    do_read(5'd0);
    do_write(5'd0, 8'hFF);
    do_read(5'd0);

    // request held while busy is ignored
    issue(1'b1, 5'd5, 8'h11);
    req_i = 1'b1; we_i = 1'b1; addr_i = 5'd6; wdata_i = 8'h99;
    for (int k = 1; k < TB_WTOT; k++) @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    chk(!busy_o, "R3 intruder not taken", busy_o, 0);
    chk(sram_addr_o == 18'd5, "R3 address unchanged", sram_addr_o, 5);
    shadow[5] = 8'h11;
    do_read(5'd6);
    do_read(5'd5);

    // random mix
    for (int i = 0; i < 160; i++) begin
      logic [4:0] a;
      a = 5'($urandom % 32);
      if ($urandom % 2 == 0) do_write(a, 8'($urandom));
      else do_read(a);
    end

    // full sweep
    for (int i = 0; i < 32; i++) do_write(5'(i), 8'(8'h5A ^ (i * 13)));
    for (int i = 0; i < 32; i++) do_read(5'(i));

    repeat (2) @(negedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule